// File: doc/BRIEF.md
# SIMD Lane Load Decode and Merge Unit

This unit executes one single-structure vector load. It decodes the encoding bits into four things: an element width, a lane number, a register count and a replicate flag. It rejects encodings that are not allowed. For each destination register it issues one element read on a simple memory request port. It then merges the returned element into a 128-bit vector register through a read-modify-write port on the register file.

In lane mode, the element replaces one lane and every other bit of the register is kept. In replicate mode, the element is copied across either the low 64 bits or the full 128 bits. When only 64 bits are filled, the upper half is cleared. A command may cover one to four registers. Each step moves the memory offset on by one element and the register number on by one, wrapping from 31 to 0.

Address translation, alignment and tag checks, ordering enforcement and base writeback are left to the surrounding pipeline.

Top module: `vlane_ld_unit`

## Requirements
- R1: The register count equals {opcode[0], r} + 1, and a legal command produces exactly that many register writes and memory requests.
- R2: When opcode[2:1] = 3 the command replicates with element width 8 << size. It is rejected as undefined unless l = 1 and s = 0.
- R3: When opcode[2:1] = 0 the element is one byte, and the lane is {q, s, size}, from 0 to 15.
- R4: When opcode[2:1] = 1 the element is two bytes, and the lane is {q, s, size[1]}. A command with size[0] = 1 is undefined.
- R5: When opcode[2:1] = 2, size[1] = 1 is undefined. With size[0] = 0 the element is four bytes and the lane is {q, s}. With size[0] = 1 the element is eight bytes and the lane is q, and s = 1 is undefined.
- R6: In lane mode the written register equals the old register contents, with only bytes [lane*E, lane*E+E) replaced by the low E bytes of the returned data, where E is the element byte count.
- R7: In replicate mode the element fills bytes 0..7 when q = 0, or bytes 0..15 when q = 1. When q = 0, bytes 8..15 are written as zero.
- R8: Register k of a command (k from 0) goes to register (rt + k) mod 32. Its request address is base + k*E, and its size code is log2(E).
- R9: A request holds its address and size code until accepted (mem_req_valid && mem_req_ready at a rising edge). Only one request is in flight, and no new request is raised before its response has been written.
- R10: An undefined command raises undef for exactly one cycle, in the cycle after acceptance. It issues no memory request and no register write.
- R11: done pulses for one cycle, in the cycle after the last register write of a legal command.
- R12: After reset, cmd_ready is 1 and mem_req_valid, rf_wr_en, undef and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_q | input | 1 | Upper-half / wide-destination bit |
| cmd_l | input | 1 | Load bit, checked in replicate mode |
| cmd_r | input | 1 | Low bit of register count |
| cmd_s | input | 1 | Lane select bit |
| cmd_opcode | input | 3 | Scale in [2:1], count high bit in [0] |
| cmd_size | input | 2 | Size field |
| cmd_rt | input | 5 | First destination register |
| cmd_base | input | ADDR_W | Base byte address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_size | output | 2 | log2 of element byte count |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | MEM_W | Read data, element in low bytes |
| rf_rd_idx | output | 5 | Register being merged |
| rf_rd_data | input | 128 | Current contents of that register |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 5 | Register written |
| rf_wr_data | output | 128 | Merged register value |
| undef | output | 1 | Undefined-encoding pulse |
| done | output | 1 | Command complete pulse |

## Verification
The assertions take three things for granted about the environment. mem_rsp_valid is raised only while a request is outstanding. The register file returns on rf_rd_data, in the same cycle, the contents of the register named on rf_rd_idx. mem_rsp_data carries the element in its low bytes. The bench's memory model answers only requests it has accepted, one at a time and after a varying delay, while mem_req_ready follows a repeating pattern that stalls some requests. Its register model is a plain array read combinationally and written on rf_wr_en. Commands are offered only while cmd_ready is high, and are held for exactly the one cycle in which they are accepted.

// File: rtl/vlane_ld_pkg.sv
package vlane_ld_pkg;

  typedef struct packed {
    logic       undef;
    logic       rep;
    logic [1:0] esz;      // log2 of element byte count
    logic [3:0] lane;
    logic [1:0] nreg_m1;
    logic       q;
  } vld_dec_t;

  // Turns encoding bits into element width, lane, count and legality
  function automatic vld_dec_t vld_decode(input logic q, input logic l,
                                          input logic s, input logic r,
                                          input logic [2:0] opc,
                                          input logic [1:0] size);
    vld_dec_t d;
    d = '0;
    d.q = q;
    d.nreg_m1 = {opc[0], r};
    case (opc[2:1])
      2'd0: begin
        d.esz = 2'd0;
        d.lane = {q, s, size};
      end
      2'd1: begin
        d.esz = 2'd1;
        d.lane = {1'b0, q, s, size[1]};
        d.undef = size[0];
      end
      2'd2: begin
        if (size[0]) begin
          d.esz = 2'd3;
          d.lane = {3'b000, q};
          d.undef = size[1] | s;
        end else begin
          d.esz = 2'd2;
          d.lane = {2'b00, q, s};
          d.undef = size[1];
        end
      end
      default: begin
        d.rep = 1'b1;
        d.esz = size;
        d.undef = !l || s;
      end
    endcase
    return d;
  endfunction

  // Element byte count for a size code
  function automatic logic [3:0] vld_ebytes(input logic [1:0] esz);
    return 4'd1 << esz;
  endfunction

endpackage

// File: rtl/vlane_ld_decode.sv
module vlane_ld_decode
  import vlane_ld_pkg::*;
(
  input  logic       q,
  input  logic       l,
  input  logic       s,
  input  logic       r,
  input  logic [2:0] opc,
  input  logic [1:0] size,
  output vld_dec_t   dec
);

  assign dec = vld_decode(q, l, s, r, opc, size);

  // A legal lane must fit inside 16 bytes for its element width
  always_comb begin
    if (!dec.undef && !dec.rep)
      a_r3_lane_in_range: assert ((5'(dec.lane) << dec.esz) < 5'd16);
  end

endmodule

// File: rtl/vlane_ld_merge.sv
module vlane_ld_merge #(
  parameter int VEC_W = 128,
  parameter int MEM_W = 64
) (
  input  logic [VEC_W-1:0] old_i,
  input  logic [MEM_W-1:0] elem_i,
  input  logic [1:0]       esz_i,
  input  logic [3:0]       lane_i,
  input  logic             rep_i,
  input  logic             q_i,
  output logic [VEC_W-1:0] new_o
);

  localparam int VBYTES = VEC_W / 8;
  localparam int HALF   = VBYTES / 2;
  localparam int SELW   = $clog2(MEM_W / 8);

  for (genvar b = 0; b < VBYTES; b++) begin : g_byte
    logic [4:0]      st;
    logic [4:0]      nb;
    logic [SELW-1:0] sel;
    logic            hit;
    logic            clr;
    logic [7:0]      nbyte;

    always_comb begin
      nb  = 5'd1 << esz_i;
      st  = 5'(lane_i) << esz_i;
      hit = (5'(b) >= st) && (5'(b) < st + nb);
      sel = rep_i ? SELW'(5'(b) & (nb - 5'd1)) : SELW'(5'(b) - st);
      clr = rep_i && !q_i && (b >= HALF);
      if (clr)
        nbyte = 8'h00;
      else if (rep_i || hit)
        nbyte = elem_i[{sel, 3'b000} +: 8];
      else
        nbyte = old_i[8*b +: 8];
    end

    assign new_o[8*b +: 8] = nbyte;

    // R6: bytes outside the lane leave the merge unchanged
    always_comb begin
      if (!rep_i && !hit)
        a_r6_keep_outside: assert (new_o[8*b +: 8] == old_i[8*b +: 8]);
      if (clr)
        a_r7_upper_zero: assert (new_o[8*b +: 8] == 8'h00);
    end
  end

endmodule

// File: rtl/vlane_ld_seq.sv
module vlane_ld_seq
  import vlane_ld_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int NREG   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  vld_dec_t          dec_i,
  input  logic [$clog2(NREG)-1:0] rt_i,
  input  logic [ADDR_W-1:0] base_i,
  output vld_dec_t          dec_q,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  input  logic              mem_rsp_valid,
  output logic [$clog2(NREG)-1:0] cur_reg,
  output logic              wr_en,
  output logic              undef,
  output logic              done
);

  localparam int REG_W = $clog2(NREG);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t               st_q;
  logic [1:0]        cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] offs_q;
  logic [REG_W-1:0]  reg_q;
  logic              undef_q;
  logic              done_q;

  // Named internal events
  logic accept;
  logic req_fire;
  logic wr_fire;
  logic last_wr;

  assign cmd_ready = (st_q == S_IDLE) && !undef_q && !done_q;
  assign accept    = cmd_valid && cmd_ready;
  assign req_fire  = mem_req_valid && mem_req_ready;
  assign wr_fire   = (st_q == S_WAIT) && mem_rsp_valid;
  assign last_wr   = wr_fire && (cnt_q == dec_q.nreg_m1);

  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = base_q + offs_q;
  assign mem_req_size  = dec_q.esz;
  assign cur_reg       = reg_q;
  assign wr_en         = wr_fire;
  assign undef         = undef_q;
  assign done          = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      offs_q  <= '0;
      reg_q   <= '0;
      dec_q   <= '0;
      undef_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      undef_q <= accept && dec_i.undef;
      done_q  <= last_wr;
      case (st_q)
        S_IDLE: if (accept && !dec_i.undef) begin
          st_q   <= S_REQ;
          dec_q  <= dec_i;
          base_q <= base_i;
          offs_q <= '0;
          cnt_q  <= '0;
          reg_q  <= rt_i;
        end
        S_REQ: if (req_fire) st_q <= S_WAIT;
        S_WAIT: if (wr_fire) begin
          if (last_wr) begin
            st_q <= S_IDLE;
          end else begin
            st_q   <= S_REQ;
            cnt_q  <= cnt_q + 2'd1;
            reg_q  <= reg_q + 1'b1;
            offs_q <= offs_q + ADDR_W'(vld_ebytes(dec_q.esz));
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R9: a stalled request keeps its address and size
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

  // R9: after an accepted request no new one appears until the write
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !mem_req_valid);

  // R10: undef is quiet and lasts one cycle
  a_r10_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !mem_req_valid && !wr_en);
  a_r10_undef_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    undef |=> !undef);

  // R11: done follows a register write
  a_r11_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en));

  // R8: consecutive writes of one command step the register by one
  a_r8_reg_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !last_wr |=> cur_reg == $past(cur_reg) + 1'b1);

endmodule

// File: rtl/vlane_ld_unit.sv
module vlane_ld_unit
  import vlane_ld_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MEM_W  = 64,
  parameter int VEC_W  = 128,
  parameter int NREG   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_q,
  input  logic                    cmd_l,
  input  logic                    cmd_r,
  input  logic                    cmd_s,
  input  logic [2:0]              cmd_opcode,
  input  logic [1:0]              cmd_size,
  input  logic [$clog2(NREG)-1:0] cmd_rt,
  input  logic [ADDR_W-1:0]       cmd_base,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [1:0]              mem_req_size,
  input  logic                    mem_rsp_valid,
  input  logic [MEM_W-1:0]        mem_rsp_data,
  output logic [$clog2(NREG)-1:0] rf_rd_idx,
  input  logic [VEC_W-1:0]        rf_rd_data,
  output logic                    rf_wr_en,
  output logic [$clog2(NREG)-1:0] rf_wr_idx,
  output logic [VEC_W-1:0]        rf_wr_data,
  output logic                    undef,
  output logic                    done
);

  localparam int REG_W = $clog2(NREG);

  vld_dec_t         dec_now;
  vld_dec_t         dec_q;
  logic [REG_W-1:0] cur_reg;

  vlane_ld_decode u_dec (
    .q    (cmd_q),
    .l    (cmd_l),
    .s    (cmd_s),
    .r    (cmd_r),
    .opc  (cmd_opcode),
    .size (cmd_size),
    .dec  (dec_now)
  );

  vlane_ld_seq #(.ADDR_W(ADDR_W), .NREG(NREG)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .dec_i         (dec_now),
    .rt_i          (cmd_rt),
    .base_i        (cmd_base),
    .dec_q         (dec_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_size  (mem_req_size),
    .mem_rsp_valid (mem_rsp_valid),
    .cur_reg       (cur_reg),
    .wr_en         (rf_wr_en),
    .undef         (undef),
    .done          (done)
  );

  vlane_ld_merge #(.VEC_W(VEC_W), .MEM_W(MEM_W)) u_merge (
    .old_i  (rf_rd_data),
    .elem_i (mem_rsp_data),
    .esz_i  (dec_q.esz),
    .lane_i (dec_q.lane),
    .rep_i  (dec_q.rep),
    .q_i    (dec_q.q),
    .new_o  (rf_wr_data)
  );

  assign rf_rd_idx = cur_reg;
  assign rf_wr_idx = cur_reg;

  // R12: idle after reset with every strobe low
  a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid && !rf_wr_en && !undef && !done);

endmodule

// File: tb/vlane_ld_unit_tb.sv
module vlane_ld_unit_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic         cmd_valid = 0, cmd_ready;
  logic         cmd_q = 0, cmd_l = 0, cmd_r = 0, cmd_s = 0;
  logic [2:0]   cmd_opcode = 0;
  logic [1:0]   cmd_size = 0;
  logic [4:0]   cmd_rt = 0;
  logic [63:0]  cmd_base = 0;
  logic         mem_req_valid, mem_req_ready = 0;
  logic [63:0]  mem_req_addr;
  logic [1:0]   mem_req_size;
  logic         mem_rsp_valid = 0;
  logic [63:0]  mem_rsp_data = 0;
  logic [4:0]   rf_rd_idx, rf_wr_idx;
  logic [127:0] rf_rd_data, rf_wr_data;
  logic         rf_wr_en, undef, done;

  vlane_ld_unit u_dut (.*);

  int compared = 0, mismatched = 0, cyc = 0;

  // register file model
  logic [127:0] rf [32];
  assign rf_rd_data = rf[rf_rd_idx];
  always @(posedge clk) if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5a;
  endfunction
  function automatic logic [63:0] mword(input logic [63:0] a);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = mbyte(a + 64'(i));
    return w;
  endfunction

  // scoreboard queues
  logic [63:0]  exp_ra[$];
  logic [1:0]   exp_rs[$];
  logic [4:0]   exp_wi[$];
  logic [127:0] exp_wd[$];
  string        exp_wt[$];

  task automatic chk(input bit ok, input string req, input string msg,
                     input logic [127:0] act, input logic [127:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, msg, act, expv);
    end
  endtask

  // memory responder
  logic        pend = 0;
  logic [63:0] paddr = 0;
  int          dly = 0;
  always begin
    @(negedge clk);
    if (mem_rsp_valid) mem_rsp_valid = 0;
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid = 1; mem_rsp_data = mword(paddr); pend = 0;
      end else dly--;
    end
    mem_req_ready = (cyc % 3) != 1;
    if (mem_req_valid && mem_req_ready && !pend && !mem_rsp_valid) begin
      pend = 1; paddr = mem_req_addr; dly = cyc % 3;
    end
  end

  // monitor
  always begin
    @(negedge clk); #1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (exp_ra.size() == 0) chk(0, "R10", "unexpected request", 128'(mem_req_addr), 0);
      else begin
        logic [63:0] ea; logic [1:0] es;
        ea = exp_ra.pop_front(); es = exp_rs.pop_front();
        chk(mem_req_addr == ea, "R8", "request address", 128'(mem_req_addr), 128'(ea));
        chk(mem_req_size == es, "R9", "request size", 128'(mem_req_size), 128'(es));
      end
    end
    if (rst_n && rf_wr_en) begin
      if (exp_wi.size() == 0) chk(0, "R10", "unexpected write", rf_wr_data, 0);
      else begin
        logic [4:0] ei; logic [127:0] ed; string t;
        ei = exp_wi.pop_front(); ed = exp_wd.pop_front(); t = exp_wt.pop_front();
        chk(rf_wr_idx == ei, "R8", "write register", 128'(rf_wr_idx), 128'(ei));
        chk(rf_wr_data == ed, t, "merged data", rf_wr_data, ed);
      end
    end
  end

  // driver: reference model pushes expectations, then runs the command
  task automatic run_cmd(input int opc, input int r, input int l, input int q,
                         input int s, input int size, input int rt,
                         input logic [63:0] base);
    int sc, eb, idx, n; bit und, rep; string ut, got;
    sc = opc >> 1; und = 0; rep = 0; eb = 1; idx = 0;
    n = ((opc & 1) * 2) + r + 1;
    if (sc == 0) begin eb = 1; idx = q*8 + s*4 + size; ut = "R3"; end
    else if (sc == 1) begin eb = 2; idx = q*4 + s*2 + size/2; und = (size % 2) == 1; ut = "R4"; end
    else if (sc == 2) begin
      ut = "R5";
      if (size >= 2) und = 1;
      else if (size == 0) begin eb = 4; idx = q*2 + s; end
      else begin eb = 8; idx = q; und = (s == 1); end
    end else begin rep = 1; eb = 1 << size; und = (l == 0) || (s == 1); ut = "R2"; end
    if (!und) begin
      for (int k = 0; k < n; k++) begin
        logic [63:0] a; logic [127:0] m, el, old, nv; int rg;
        rg = (rt + k) % 32; a = base + 64'(k * eb);
        m = (128'd1 << (8*eb)) - 128'd1;
        el = 128'(mword(a)) & m; old = rf[rg];
        if (rep) begin
          nv = '0;
          for (int c = 0; c < (q ? 16 : 8) / eb; c++) nv |= el << (8*eb*c);
        end else nv = (old & ~(m << (8*eb*idx))) | (el << (8*eb*idx));
        exp_ra.push_back(a); exp_rs.push_back(2'($clog2(eb)));
        exp_wi.push_back(5'(rg)); exp_wd.push_back(nv);
        exp_wt.push_back(rep ? "R7" : "R6");
      end
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_opcode = 3'(opc); cmd_r = r[0]; cmd_l = l[0];
    cmd_q = q[0]; cmd_s = s[0]; cmd_size = 2'(size); cmd_rt = 5'(rt); cmd_base = base;
    @(negedge clk); cmd_valid = 0;
    #1;
    while (!(done || undef)) begin @(negedge clk); #1; end
    chk(undef == und, ut, "undefined decision", 128'(undef), 128'(und));
    if (und) begin
      @(negedge clk); #1;
      chk(undef == 0, "R10", "undef pulse width", 128'(undef), 0);
    end else begin
      chk(exp_wi.size() == 0, "R1", "writes remaining", 128'(exp_wi.size()), 0);
      @(negedge clk); #1;
      chk(done == 0, "R11", "done pulse width", 128'(done), 0);
    end
    exp_ra.delete(); exp_rs.delete(); exp_wi.delete(); exp_wd.delete(); exp_wt.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int k;
    for (int i = 0; i < 32; i++) rf[i] = {4{32'(i * 32'h9e3779b9 + 32'h1357)}};
    repeat (3) @(negedge clk);
    #1;
    chk(cmd_ready == 1, "R12", "reset cmd_ready", 128'(cmd_ready), 1);
    chk({mem_req_valid, rf_wr_en, undef, done} == 0, "R12", "reset strobes",
        128'({mem_req_valid, rf_wr_en, undef, done}), 0);
    rst_n = 1;
    k = 0;
    for (int opc = 0; opc < 8; opc++)
      for (int r = 0; r < 2; r++)
        for (int l = 0; l < 2; l++)
          for (int q = 0; q < 2; q++)
            for (int s = 0; s < 2; s++)
              for (int size = 0; size < 4; size++) begin
                run_cmd(opc, r, l, q, s, size, (k * 7 + 29) % 32,
                        64'hffff_ffff_ffff_fff0 + 64'(k * 37));
                k++;
              end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule